// File: doc/BRIEF.md
# Exception Gating and Entry Controller

This block sits beside a processor's instruction sequencer. Each cycle it decides whether any pending exception condition may be taken. The decision uses the enable bits of the machine state register (MSR), which the block holds itself. Exception requests arrive as one-cycle pulses and are latched as pending. The requests are: system reset, per-source machine check signals filtered by a configuration enable mask, external interrupt, decrementer, performance monitor, and floating-point program exception.

When an exception is taken, the block does the following in one clock edge:
- saves the interrupted instruction address in SRR0;
- saves the old MSR in SRR1;
- applies the entry changes to the MSR;
- raises a one-cycle take strobe with the vector offset.

A return input reloads the MSR from SRR1. A write port lets software load the MSR directly.

A machine check that arrives while machine checks are disabled sends the block into a sticky checkstop. In checkstop it takes no further exceptions until hardware reset.

The controller is a two-state machine:
- ST_RUN is the normal state. It stays in ST_RUN while no checkstop condition exists.
- The transition ST_RUN to ST_CHKSTOP fires when a machine check is pending, MSR.ME is 0 and no system reset is pending.
- ST_CHKSTOP has only a self-loop. Only `rst_n` leaves it.

MSR bit positions (bit 0 is the LSB):

| Bit | Field |
|-----|-------|
| 15 | EE |
| 12 | ME |
| 11 | FE0 |
| 8 | FE1 |
| 2 | PM |
| 1 | RI |
| 0 | LE (1 = little-endian, 0 = big-endian) |

Top module: `exc_gate_ctrl`

## Requirements
- R1: After reset: `take`=0, `vector`=0, `checkstop`=0, `srr0`=`srr1`=0 and `msr`=0x0000_1000 (only ME set).
- R2: A system reset request is taken whatever the MSR holds, with vector 0x100. It also has the highest priority.
- R3: A machine check source raises a request only when its bit in `mc_en` is 1. An enabled source taken while ME=1 gives vector 0x200.
- R4: A pending machine check with ME=0 (and no pending system reset) enters sticky checkstop. `checkstop` stays 1, and no exception is taken afterwards, a system reset request included.
- R5: External (0x500) and decrementer (0x900) requests are taken only while EE=1. While EE=0 they remain pending and are taken once EE becomes 1.
- R6: A performance monitor request (vector 0xF00) is taken only while PM=1. Otherwise it stays pending.
- R7: The floating-point mode is {FE0,FE1}. With 00, a floating-point request is ignored and not remembered. With 01, 10 or 11, it is taken as a precise program exception with vector 0x700.
- R8: Priority, highest first: system reset, machine check, program, external, performance monitor, decrementer. At most one exception is taken per cycle. Lower ones stay pending.
- R9: On entry, SRR0 gets `pc` and SRR1 gets the MSR from before the entry. In the MSR, EE is cleared; for system reset and machine check, ME and RI are also cleared. All other bits are kept.
- R10: A request pulse sampled on clock edge k produces `take`=1 for exactly the cycle after edge k+1, with `vector` valid then. `vector` is 0 whenever `take` is 0.
- R11: `rfi` loads the MSR from SRR1 on the next edge. `msr_wr` loads `msr_wdata`. Precedence on one edge is: exception entry, then `rfi`, then `msr_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sreset_req | input | 1 | System reset request pulse |
| mc_src | input | NMC | Machine check source pulses |
| mc_en | input | NMC | Per-source machine check enables |
| ext_req | input | 1 | External interrupt request pulse |
| dec_req | input | 1 | Decrementer request pulse |
| pm_req | input | 1 | Performance monitor request pulse |
| fp_req | input | 1 | Floating-point exception request pulse |
| rfi | input | 1 | Return: restore MSR from SRR1 |
| msr_wr | input | 1 | MSR write enable |
| msr_wdata | input | 32 | MSR write data |
| pc | input | AW | Address of the current instruction |
| take | output | 1 | One-cycle exception taken strobe |
| vector | output | 12 | Vector offset of the taken exception |
| checkstop | output | 1 | Sticky checkstop indication |
| msr | output | 32 | Current machine state register |
| srr0 | output | AW | Saved instruction address |
| srr1 | output | 32 | Saved MSR |

## Verification
The assertions check several properties on every cycle:
- each take leaves EE clear and SRR1 equal to the MSR of the cycle before;
- system reset entry leaves ME and RI clear;
- `vector` is nonzero exactly when `take` is high;
- checkstop never falls back and never coexists with a take.

Some behaviours only the bench scenarios can show. These are the gating that keeps external, decrementer and performance monitor requests waiting until their enable appears, the discarding of floating-point requests in mode 00, and the full priority order under simultaneous requests. The bench's reference model tracks them cycle by cycle and compares every output.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int MSR_W = 32;
    localparam int VEC_W = 12;

    // MSR field positions (LSB = bit 0)
    localparam int B_EE  = 15;
    localparam int B_ME  = 12;
    localparam int B_FE0 = 11;
    localparam int B_FE1 = 8;
    localparam int B_PM  = 2;
    localparam int B_RI  = 1;
    localparam int B_LE  = 0;

    localparam logic [MSR_W-1:0] MSR_RST = 32'h0000_1000;

    // exception classes, index order is priority order (0 highest)
    localparam int NCLS = 6;
    typedef enum logic [2:0] {
        C_SRESET = 3'd0,
        C_MCHK   = 3'd1,
        C_PROG   = 3'd2,
        C_EXT    = 3'd3,
        C_PMON   = 3'd4,
        C_DEC    = 3'd5,
        C_NONE   = 3'd7
    } exc_cls_e;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_CHKSTOP = 1'b1
    } gate_st_e;

    function automatic logic [VEC_W-1:0] cls_vector(exc_cls_e c);
        logic [VEC_W-1:0] v;
        unique case (c)
            C_SRESET: v = 12'h100;
            C_MCHK:   v = 12'h200;
            C_PROG:   v = 12'h700;
            C_EXT:    v = 12'h500;
            C_PMON:   v = 12'hF00;
            C_DEC:    v = 12'h900;
            default:  v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/exc_pending.sv
module exc_pending
    import exc_pkg::*;
#(
    parameter int NMC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sreset_req,
    input  logic [NMC-1:0]  mc_src,
    input  logic [NMC-1:0]  mc_en,
    input  logic            ext_req,
    input  logic            dec_req,
    input  logic            pm_req,
    input  logic            fp_req,
    input  logic            fp_on,
    input  logic            clr_vld,
    input  exc_cls_e        clr_cls,
    output logic [NCLS-1:0] pend
);
    logic [NCLS-1:0] set_v;

    always_comb begin
        set_v           = '0;
        set_v[C_SRESET] = sreset_req;
        set_v[C_MCHK]   = |(mc_src & mc_en);
        set_v[C_PROG]   = fp_req & fp_on;
        set_v[C_EXT]    = ext_req;
        set_v[C_PMON]   = pm_req;
        set_v[C_DEC]    = dec_req;
    end

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        logic clr_here;
        assign clr_here = clr_vld && (clr_cls == exc_cls_e'(3'(i)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= (pend[i] & ~clr_here) | set_v[i];
        end
    end
endmodule

// File: rtl/exc_priority.sv
module exc_priority
    import exc_pkg::*;
(
    input  logic [NCLS-1:0]  pend,
    input  logic [MSR_W-1:0] msr,
    input  logic             running,
    output logic             take_vld,
    output exc_cls_e         cls,
    output logic             stop_req
);
    logic [NCLS-1:0] elig;

    always_comb begin
        elig           = '0;
        elig[C_SRESET] = pend[C_SRESET];
        elig[C_MCHK]   = pend[C_MCHK] & msr[B_ME];
        elig[C_PROG]   = pend[C_PROG] & (msr[B_FE0] | msr[B_FE1]);
        elig[C_EXT]    = pend[C_EXT]  & msr[B_EE];
        elig[C_PMON]   = pend[C_PMON] & msr[B_PM];
        elig[C_DEC]    = pend[C_DEC]  & msr[B_EE];
    end

    always_comb begin
        stop_req = running & pend[C_MCHK] & ~msr[B_ME] & ~pend[C_SRESET];
        take_vld = 1'b0;
        cls      = C_NONE;
        if (running && !stop_req) begin
            for (int i = NCLS - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    take_vld = 1'b1;
                    cls      = exc_cls_e'(3'(i));
                end
            end
        end
    end
endmodule

// File: rtl/exc_gate_ctrl.sv
module exc_gate_ctrl
    import exc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NMC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sreset_req,
    input  logic [NMC-1:0]   mc_src,
    input  logic [NMC-1:0]   mc_en,
    input  logic             ext_req,
    input  logic             dec_req,
    input  logic             pm_req,
    input  logic             fp_req,
    input  logic             rfi,
    input  logic             msr_wr,
    input  logic [MSR_W-1:0] msr_wdata,
    input  logic [AW-1:0]    pc,
    output logic             take,
    output logic [VEC_W-1:0] vector,
    output logic             checkstop,
    output logic [MSR_W-1:0] msr,
    output logic [AW-1:0]    srr0,
    output logic [MSR_W-1:0] srr1
);
    gate_st_e        st_q, st_d;
    logic [NCLS-1:0] pend;
    logic            take_vld, stop_req, running;
    exc_cls_e        cls;
    logic [MSR_W-1:0] msr_ent;

    assign running   = (st_q == ST_RUN);
    assign checkstop = (st_q == ST_CHKSTOP);

    exc_pending #(.NMC(NMC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .sreset_req (sreset_req),
        .mc_src     (mc_src),
        .mc_en      (mc_en),
        .ext_req    (ext_req),
        .dec_req    (dec_req),
        .pm_req     (pm_req),
        .fp_req     (fp_req),
        .fp_on      (msr[B_FE0] | msr[B_FE1]),
        .clr_vld    (take_vld),
        .clr_cls    (cls),
        .pend       (pend)
    );

    exc_priority u_prio (
        .pend     (pend),
        .msr      (msr),
        .running  (running),
        .take_vld (take_vld),
        .cls      (cls),
        .stop_req (stop_req)
    );

    // next state
    always_comb begin
        unique case (st_q)
            ST_RUN:     st_d = stop_req ? ST_CHKSTOP : ST_RUN;
            ST_CHKSTOP: st_d = ST_CHKSTOP;
            default:    st_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // MSR image written on exception entry
    always_comb begin
        msr_ent       = msr;
        msr_ent[B_EE] = 1'b0;
        if (cls == C_SRESET || cls == C_MCHK) begin
            msr_ent[B_ME] = 1'b0;
            msr_ent[B_RI] = 1'b0;
        end
    end

    // outputs and saved state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take   <= 1'b0;
            vector <= '0;
            msr    <= MSR_RST;
            srr0   <= '0;
            srr1   <= '0;
        end else if (take_vld) begin
            take   <= 1'b1;
            vector <= cls_vector(cls);
            srr0   <= pc;
            srr1   <= msr;
            msr    <= msr_ent;
        end else begin
            take   <= 1'b0;
            vector <= '0;
            if (rfi)         msr <= srr1;
            else if (msr_wr) msr <= msr_wdata;
        end
    end
endmodule

// File: rtl/exc_gate_chk.sv
module exc_gate_chk
    import exc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             take,
    input logic [VEC_W-1:0] vector,
    input logic             checkstop,
    input logic [MSR_W-1:0] msr,
    input logic [MSR_W-1:0] srr1
);
    // R9
    ee_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !msr[B_EE]);

    // R9
    srr1_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> srr1 == $past(msr));

    // R2
    rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vector == 12'h100) |-> (!msr[B_ME] && !msr[B_RI]));

    // R4
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);

    // R4
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |-> !take);

    // R10
    vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take == (vector != '0));
endmodule

bind exc_gate_ctrl exc_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .vector    (vector),
    .checkstop (checkstop),
    .msr       (msr),
    .srr1      (srr1)
);

// File: tb/test_exc_gate_ctrl.sv
module test_exc_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sreset_req = 0, ext_req = 0, dec_req = 0, pm_req = 0, fp_req = 0;
    logic        rfi = 0, msr_wr = 0;
    logic [3:0]  mc_src = '0, mc_en = '0;
    logic [31:0] msr_wdata = '0, pc = '0;
    logic        take, checkstop;
    logic [11:0] vector;
    logic [31:0] msr, srr0, srr1;

    int    nchk = 0, nbad = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    exc_gate_ctrl #(.AW(32), .NMC(4)) i_exc_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .sreset_req(sreset_req), .mc_src(mc_src),
        .mc_en(mc_en), .ext_req(ext_req), .dec_req(dec_req), .pm_req(pm_req),
        .fp_req(fp_req), .rfi(rfi), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
        .pc(pc), .take(take), .vector(vector), .checkstop(checkstop),
        .msr(msr), .srr0(srr0), .srr1(srr1)
    );

    // ---------------- behavioural reference model ----------------
    bit [5:0]    mp, mset;
    logic [31:0] m_msr, m_srr0, m_srr1;
    logic [11:0] m_vec;
    bit          m_take, m_stop, stopnow;
    int          sel;
    logic [11:0] vtab [6] = '{12'h100, 12'h200, 12'h700, 12'h500, 12'hF00, 12'h900};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mp = '0; m_msr = 32'h1000; m_srr0 = '0; m_srr1 = '0;
            m_vec = '0; m_take = 0; m_stop = 0;
        end else begin
            sel = -1; stopnow = 0;
            if (!m_stop) begin
                if (mp[0]) sel = 0;
                else if (mp[1]) begin
                    if (m_msr[12]) sel = 1; else stopnow = 1;
                end
                else if (mp[2] && (m_msr[11] || m_msr[8])) sel = 2;
                else if (mp[3] && m_msr[15]) sel = 3;
                else if (mp[4] && m_msr[2])  sel = 4;
                else if (mp[5] && m_msr[15]) sel = 5;
            end
            mset = {dec_req, pm_req, ext_req, fp_req && (m_msr[11] || m_msr[8]),
                    |(mc_src & mc_en), sreset_req};
            m_take = (sel >= 0);
            m_vec  = '0;
            if (sel >= 0) begin
                mp[sel] = 1'b0;
                m_vec   = vtab[sel];
                m_srr0  = pc;
                m_srr1  = m_msr;
                m_msr[15] = 1'b0;
                if (sel < 2) begin m_msr[12] = 1'b0; m_msr[1] = 1'b0; end
            end else if (rfi)    m_msr = m_srr1;
            else if (msr_wr)     m_msr = msr_wdata;
            mp = mp | mset;
            if (stopnow) m_stop = 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            nchk++;
            if (take !== m_take || vector !== m_vec || checkstop !== m_stop ||
                msr !== m_msr || srr0 !== m_srr0 || srr1 !== m_srr1) begin
                nbad++;
                $display("FAIL %s model act=%b/%h/%b/%h/%h/%h exp=%b/%h/%b/%h/%h/%h",
                         cur_req, take, vector, checkstop, msr, srr0, srr1,
                         m_take, m_vec, m_stop, m_msr, m_srr0, m_srr1);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_msr(input logic [31:0] v);
        msr_wr = 1; msr_wdata = v; step(); msr_wr = 0;
    endtask

    task automatic go(input bit sr, input logic [3:0] mc, input bit ex, input bit dc,
                      input bit pmr, input bit fp);
        sreset_req = sr; mc_src = mc; ext_req = ex; dec_req = dc; pm_req = pmr; fp_req = fp;
        step();
        sreset_req = 0; mc_src = '0; ext_req = 0; dec_req = 0; pm_req = 0; fp_req = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL R10 watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        cur_req = "R1";
        chk("R1 msr", msr, 32'h1000);
        chk("R1 take", {31'd0, take}, 0);
        chk("R1 checkstop", {31'd0, checkstop}, 0);
        chk("R1 srr0", srr0, 0);

        // R2 / R9 / R10: system reset entry
        cur_req = "R2"; pc = 32'h100C;
        go(1, 0, 0, 0, 0, 0); step();
        chk("R2 take", {31'd0, take}, 1);
        chk("R2 vector", {20'd0, vector}, 32'h100);
        chk("R9 srr0", srr0, 32'h100C);
        chk("R9 srr1", srr1, 32'h1000);
        chk("R9 msr", msr, 32'h0);
        step();
        chk("R10 single pulse", {31'd0, take}, 0);

        // R3: masked source ignored, enabled source taken
        cur_req = "R3"; pc = 32'h2000;
        wr_msr(32'h1002); mc_en = 4'b0100;
        go(0, 4'b0011, 0, 0, 0, 0); step(); step();
        chk("R3 masked source", {31'd0, take}, 0);
        go(0, 4'b0100, 0, 0, 0, 0); step();
        chk("R3 vector", {20'd0, vector}, 32'h200);
        chk("R9 mc msr", msr, 32'h0);
        chk("R9 mc srr1", srr1, 32'h1002);

        // R5: external held while EE=0
        cur_req = "R5"; pc = 32'h3000;
        wr_msr(32'h1000);
        go(0, 0, 1, 0, 0, 0); step(); step(); step();
        chk("R5 held", {31'd0, take}, 0);
        wr_msr(32'h9000); step();
        chk("R5 vector", {20'd0, vector}, 32'h500);
        chk("R9 EE cleared", msr, 32'h1000);

        // R8: priority under simultaneous requests
        cur_req = "R8"; pc = 32'h4000;
        wr_msr(32'h9904);
        go(0, 0, 1, 1, 1, 1); step();
        chk("R8 first program", {20'd0, vector}, 32'h700);
        step();
        chk("R8 second pmon", {20'd0, vector}, 32'hF00);
        wr_msr(32'h9904); step();
        chk("R8 third external", {20'd0, vector}, 32'h500);
        wr_msr(32'h9904); step();
        chk("R8 fourth decrementer", {20'd0, vector}, 32'h900);

        // R7: floating-point modes
        cur_req = "R7"; pc = 32'h5000;
        wr_msr(32'h1000);
        go(0, 0, 0, 0, 0, 1); step(); step();
        chk("R7 mode 00 no take", {31'd0, take}, 0);
        wr_msr(32'h1800); step();
        chk("R7 mode 00 not remembered", {31'd0, take}, 0);
        go(0, 0, 0, 0, 0, 1); step();
        chk("R7 mode 10", {20'd0, vector}, 32'h700);
        wr_msr(32'h1100);
        go(0, 0, 0, 0, 0, 1); step();
        chk("R7 mode 01", {20'd0, vector}, 32'h700);
        wr_msr(32'h1900);
        go(0, 0, 0, 0, 0, 1); step();
        chk("R7 mode 11", {20'd0, vector}, 32'h700);

        // R6: performance monitor gated by PM
        cur_req = "R6"; pc = 32'h6000;
        wr_msr(32'h1000);
        go(0, 0, 0, 0, 1, 0); step(); step();
        chk("R6 held", {31'd0, take}, 0);
        wr_msr(32'h1004); step();
        chk("R6 vector", {20'd0, vector}, 32'hF00);
        chk("R9 srr0 pmon", srr0, 32'h6000);

        // R11: write then return
        cur_req = "R11";
        wr_msr(32'h0003);
        chk("R11 write", msr, 32'h0003);
        rfi = 1; step(); rfi = 0;
        chk("R11 rfi restore", msr, 32'h1004);

        // R4: checkstop entry and stickiness
        cur_req = "R4";
        wr_msr(32'h0000); mc_en = 4'b1111;
        go(0, 4'b0001, 0, 0, 0, 0); step();
        chk("R4 checkstop", {31'd0, checkstop}, 1);
        chk("R4 no take", {31'd0, take}, 0);
        go(1, 0, 0, 0, 0, 0); step(); step();
        chk("R4 reset ignored", {31'd0, take}, 0);
        wr_msr(32'h9000);
        go(0, 0, 1, 0, 0, 0); step(); step();
        chk("R4 external ignored", {31'd0, take}, 0);
        chk("R4 still stopped", {31'd0, checkstop}, 1);

        finish_run();
    end
endmodule